// File: doc/BRIEF.md
# Two-Bank Indexed CMOS Register Port

This block puts a host-facing pointer/data window in front of a 256-byte battery-backed store. The same store also holds the clock registers. The host reaches the store through a 2-bit port offset, with separate write and read strobes. There are two window pairs. Offsets 0 and 1 serve the lower 128 bytes, and offsets 2 and 3 serve the upper 128 bytes. The host first writes a 7-bit pointer to an even offset. It then reads or writes the byte at that pointer through the odd offset directly above it. The upper half cannot be reached through the lower pair, because the pointer holds only 7 bits.

The lower half starts with the time fields (seconds, alarms, minutes, hours, weekday, date, month, year) and the control registers, and this block stores all of them as plain bytes. Two lower-bank locations behave differently:
- Location 12 is an interrupt-flag byte. The clock core sets its bits through a side input, and a host read of location 12 clears it.
- Location 13 is a status byte. It reads with bit 7 (valid RAM and time) set.

The host cannot write either of these two locations. Read data is registered and arrives one cycle after the read strobe.

Top module: `cmos_bank_port`

## Requirements
- R1: A write at offset 0 loads io_wdata[6:0] into the lower pointer and ignores io_wdata[7]. A read at offset 0 returns {1'b0, lower pointer}.
- R2: A write at offset 2 loads io_wdata[6:0] into the upper pointer and ignores io_wdata[7]. A read at offset 2 returns {1'b0, upper pointer}.
- R3: A write at offset 1 stores io_wdata at byte address P, where P is the lower pointer, except when P is 12 or 13. A read at offset 1 returns that byte. This applies to locations 0 to 11 (time fields and control bytes) and 14 to 127.
- R4: Offset 3 accesses byte address 128 + Q, where Q is the upper pointer, and has no special locations. The two halves are separate storage: upper pointer value k never touches lower byte k.
- R5: io_rdata takes its new value on the first rising edge after a cycle with io_rd high. It holds that value through every cycle without io_rd, writes included.
- R6: A read of lower location 13 returns 8'h80 (bit 7 = valid). Writes to location 13 have no effect.
- R7: Writes to lower location 12 have no effect. Each bit set in clk_flag_set in a cycle is OR-ed into the flag byte at the next edge and stays set until that byte is read.
- R8: A read of lower location 12 returns the flag byte as it stood before the read, then clears it. Bits presented on clk_flag_set in the same cycle as the read survive the clear.
- R9: After rst, both pointers are 0, the flag byte is 0 and io_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_ofs | input | 2 | Port offset: 0/2 pointer, 1/3 data; bit 1 selects the bank |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| clk_flag_set | input | 8 | Flag bits posted by the clock core, OR-ed into location 12 |

## Verification
The following are checked by properties on every cycle:
- A pointer write lands on the next edge.
- io_rdata holds still in cycles without a read.
- Status reads return the valid pattern.
- The flag byte never loses a bit except through a read.
- A clearing read keeps only the same-cycle set bits.

The following can only be shown by the bench's scenarios, since they depend on what was stored earlier:
- The two banks are separate.
- Reads of stored bytes return what was written.
- Writes to locations 12 and 13 are discarded.
- Pointer bit 7 is dropped, which shows in the pointer readback.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  // offset decode: bit 0 picks data vs pointer, bit 1 picks the bank
  typedef enum logic [1:0] {
    PORT_PTR_LO = 2'd0,
    PORT_DAT_LO = 2'd1,
    PORT_PTR_HI = 2'd2,
    PORT_DAT_HI = 2'd3
  } port_sel_e;

  typedef enum logic {
    SRC_SIDE = 1'b0,
    SRC_RAM  = 1'b1
  } rd_src_e;
endpackage

// File: rtl/cmos_index_regs.sv
module cmos_index_regs #(
  parameter int DATA_W  = 8,
  parameter int BANK_AW = 7,
  parameter int NBANK   = 2,
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ptr_wr,
  input  logic [BSEL_W-1:0]               bank_sel,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NBANK-1:0][BANK_AW-1:0]   ptr_q
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) ptr_q[b] <= '0;
      else if (ptr_wr && bank_sel == BSEL_W'(b)) ptr_q[b] <= wdata[BANK_AW-1:0];
    end

    // R1/R2: a pointer write shows up on the following edge
    a_r1_ptr_load: assert property (@(posedge clk) disable iff (rst)
      (ptr_wr && bank_sel == BSEL_W'(b)) |=> ptr_q[b] == $past(wdata[BANK_AW-1:0]));
  end
endmodule

// File: rtl/cmos_ram.sv
module cmos_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/cmos_flag_reg.sv
module cmos_flag_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)        flags_q <= '0;
    else if (clr_i) flags_q <= set_i;
    else            flags_q <= flags_q | set_i;
  end

  // R7: without a clearing read no bit is ever lost
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R8: a clearing read keeps only bits posted in that same cycle
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> flags_q == $past(set_i));
endmodule

// File: rtl/cmos_bank_port.sv
module cmos_bank_port #(
  parameter int                 DATA_W     = 8,
  parameter int                 BANK_AW    = 7,
  parameter int                 FLAG_IDX   = 12,
  parameter int                 STAT_IDX   = 13,
  parameter logic [DATA_W-1:0]  STAT_VALUE = 8'h80,
  localparam int                NBANK      = 2,
  localparam int                ADDR_W     = BANK_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_ofs,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] clk_flag_set
);
  import cmos_pkg::*;

  logic                            is_data;
  logic                            bank;
  logic [NBANK-1:0][BANK_AW-1:0]   ptr_q;
  logic [BANK_AW-1:0]              cur_ptr;
  logic [ADDR_W-1:0]               addr;
  logic                            hit_flag, hit_stat;
  logic                            ram_we, ram_re, flag_clr;
  logic [DATA_W-1:0]               ram_q, flags_q, side_q;
  rd_src_e                         src_q;

  assign is_data  = io_ofs[0];
  assign bank     = io_ofs[1];
  assign cur_ptr  = ptr_q[bank];
  assign addr     = {bank, cur_ptr};
  assign hit_flag = !bank && cur_ptr == BANK_AW'(FLAG_IDX);
  assign hit_stat = !bank && cur_ptr == BANK_AW'(STAT_IDX);
  assign ram_we   = io_wr && is_data && !hit_flag && !hit_stat;
  assign ram_re   = io_rd && is_data;
  assign flag_clr = io_rd && is_data && hit_flag;

  cmos_index_regs #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .NBANK(NBANK)) u_ptr (
    .clk(clk), .rst(rst), .ptr_wr(io_wr && !is_data), .bank_sel(bank),
    .wdata(io_wdata), .ptr_q(ptr_q));

  cmos_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(addr), .wdata(io_wdata),
    .re(ram_re), .raddr(addr), .rdata_q(ram_q));

  cmos_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .set_i(clk_flag_set), .clr_i(flag_clr),
    .flags_q(flags_q));

  // side path: pointer readback, flag byte and status byte
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_SIDE;
      side_q <= '0;
    end else if (io_rd) begin
      if (!is_data) begin
        src_q  <= SRC_SIDE;
        side_q <= DATA_W'(cur_ptr);
      end else if (hit_flag) begin
        src_q  <= SRC_SIDE;
        side_q <= flags_q;
      end else if (hit_stat) begin
        src_q  <= SRC_SIDE;
        side_q <= STAT_VALUE;
      end else begin
        src_q  <= SRC_RAM;
      end
    end
  end

  assign io_rdata = (src_q == SRC_RAM) ? ram_q : side_q;

  // R5: read data only moves after a read strobe
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  // R6: status reads always show the valid pattern
  a_r6_status_valid: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_ofs == PORT_DAT_LO && ptr_q[0] == BANK_AW'(STAT_IDX))
      |=> io_rdata == STAT_VALUE);
endmodule

// File: tb/test_cmos_bank_port.sv
module test_cmos_bank_port;
  logic       clk = 0;
  logic       rst = 1;
  logic       io_wr = 0, io_rd = 0;
  logic [1:0] io_ofs = 0;
  logic [7:0] io_wdata = 0, clk_flag_set = 0;
  logic [7:0] io_rdata;

  int total = 0, bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  cmos_bank_port i_cmos_bank_port (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_ofs(io_ofs),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .clk_flag_set(clk_flag_set));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares the value registered at the edge that saw the strobe
  always @(posedge clk) begin
    if (io_rd) begin
      #2;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: got %02h expected none", io_rdata);
      end else begin
        check(io_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] ofs, input logic [7:0] d);
    io_wr = 1; io_ofs = ofs; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic [1:0] ofs, input logic [7:0] exp, input string tag);
    io_rd = 1; io_ofs = ofs;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(io_rdata, 8'h00, "R9 rdata after reset");
    rd(2'd0, 8'h00, "R9 lower pointer reset");
    rd(2'd2, 8'h00, "R9 upper pointer reset");
    wr(2'd0, 8'd12);
    rd(2'd1, 8'h00, "R9 flags reset");

    // R1, R2: bit 7 of pointer writes dropped
    wr(2'd0, 8'h85);
    rd(2'd0, 8'h05, "R1 pointer readback");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h7F, "R2 pointer readback");

    // R3: plain bytes 0..11 and 14
    for (int i = 0; i < 12; i++) begin
      wr(2'd0, 8'(i)); wr(2'd1, 8'(i * 17 + 1));
    end
    wr(2'd0, 8'd14); wr(2'd1, 8'hC3);
    for (int i = 0; i < 12; i++) begin
      wr(2'd0, 8'(i)); rd(2'd1, 8'(i * 17 + 1), "R3 lower byte");
    end
    wr(2'd0, 8'd14); rd(2'd1, 8'hC3, "R3 lower byte 14");

    // R4: banks separate, no special slots in upper half
    wr(2'd0, 8'd3);  wr(2'd1, 8'h5A);
    wr(2'd2, 8'd3);  wr(2'd3, 8'hA5);
    wr(2'd2, 8'd12); wr(2'd3, 8'h3C);
    wr(2'd2, 8'd13); wr(2'd3, 8'h4B);
    wr(2'd2, 8'h8F); wr(2'd3, 8'h77);
    wr(2'd0, 8'd3);  rd(2'd1, 8'h5A, "R4 lower 3 untouched");
    wr(2'd2, 8'd3);  rd(2'd3, 8'hA5, "R4 upper 3");
    wr(2'd2, 8'd12); rd(2'd3, 8'h3C, "R4 upper 12 plain");
    wr(2'd2, 8'd13); rd(2'd3, 8'h4B, "R4 upper 13 plain");
    wr(2'd2, 8'd15); rd(2'd3, 8'h77, "R4 upper 15 via masked pointer");
    wr(2'd0, 8'd15); wr(2'd1, 8'h11);
    wr(2'd2, 8'd15); rd(2'd3, 8'h77, "R4 upper 15 after lower write");

    // R5: hold across idle and writes
    wr(2'd0, 8'd5); rd(2'd1, 8'h56, "R5 read before hold");
    wr(2'd1, 8'hEE);
    repeat (3) @(negedge clk);
    check(io_rdata, 8'h56, "R5 hold after write");
    rd(2'd1, 8'hEE, "R5 new value after read");

    // R6: status
    wr(2'd0, 8'd13); wr(2'd1, 8'h00);
    rd(2'd1, 8'h80, "R6 status valid");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h80, "R6 status after write");

    // R7: flag byte not writable, accumulates
    wr(2'd0, 8'd12); wr(2'd1, 8'hFF);
    rd(2'd1, 8'h00, "R7 flag write ignored");
    clk_flag_set = 8'h40; @(negedge clk);
    clk_flag_set = 8'h10; @(negedge clk);
    clk_flag_set = 8'h00;
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h50, "R7 flags accumulated");
    // R8: cleared by read
    rd(2'd1, 8'h00, "R8 flags cleared");
    clk_flag_set = 8'h08; @(negedge clk);
    clk_flag_set = 8'h20;
    rd(2'd1, 8'h08, "R8 read with same-cycle set");
    clk_flag_set = 8'h00;
    rd(2'd1, 8'h20, "R8 same-cycle bit survived");
    rd(2'd1, 8'h00, "R8 cleared again");

    repeat (3) @(negedge clk);
    check(8'(exp_q.size()), 8'h00, "R5 scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule